// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block watches over program execution. A binary up counter advances once per period of a slow, free-running low-speed clock. If software fails to restart it in time, the counter rolls over and the block emits a reset pulse that restarts the whole controller. It also raises a sticky flag that records the overflow. Software restarts the count with one write to a write-only clear register on the CPU register bus. The write only counts when it lands at register address 0xCC and carries the key byte 0x5A. Any other value written there leaves the count alone.

The clear request is captured in the CPU clock domain as a toggle. A chain of flip-flops carries it into the low-speed domain, so each key write produces exactly one clear. A static two-bit configuration input stands in for build-time option bits. It selects one of three modes: watchdog off; counting only while the device is awake; or counting always, including power-down and green (low-power) states. The low-power status input passes through the same synchronizer chain as the toggle.

Top module: `keyed_wdt`

## Requirements
- R1: While either reset is high and right after reset, `wdt_rst_o` and `ovf_flag_o` are low.
- R2: The counter rolls over after 2^PERIOD_LOG2 counting periods of `lsc_clk`. Without clears, successive reset pulses start exactly 2^PERIOD_LOG2 low-speed periods apart.
- R3: `wdt_rst_o` is high for exactly one `lsc_clk` period. The count is zero during that period and counting resumes from zero.
- R4: A CPU write with `bus_we_i`=1, `bus_addr_i`=0xCC and `bus_wdata_i`=0x5A zeroes the counter at the (SYNC_STAGES+1)-th `lsc_clk` rising edge after the write is captured. Number the first `lsc_clk` rising edge after the capturing `cpu_clk` edge as 1. In any counting mode, the next pulse then starts at edge 2^PERIOD_LOG2+SYNC_STAGES+1.
- R5: A write to address 0xCC with any data value other than 0x5A does not change the count.
- R6: A write of 0x5A to any address other than 0xCC does not change the count. Neither does bus activity with `bus_we_i`=0.
- R7: With `mode_i`=2'b00 (off), the counter stays at zero and no pulse or flag is produced.
- R8: With `mode_i`=2'b01 (run-only), the counter holds while `sleep_i` is high. The synchronizer delay is the same on both edges, so a sleep lasting K low-speed periods delays the next pulse by exactly K periods.
- R9: With `mode_i`=2'b10 or 2'b11 (always-on), `sleep_i` has no effect on counting.
- R10: `ovf_flag_o` rises together with the first reset pulse. It stays high through later key clears until `lsc_rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock for the register bus |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| lsc_clk | input | 1 | Low-speed oscillator clock that drives the counter |
| lsc_rst | input | 1 | Synchronous active-high reset, low-speed domain |
| mode_i | input | 2 | Static mode: 00 off, 01 run-only, 10/11 always-on |
| sleep_i | input | 1 | High while in power-down or green mode |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register write address |
| bus_wdata_i | input | 8 | Register write data |
| wdt_rst_o | output | 1 | One low-speed-period reset pulse on overflow (low-speed domain) |
| ovf_flag_o | output | 1 | Sticky overflow indicator (low-speed domain) |

## Verification
The bench sweeps all 255 wrong data values and all 255 wrong addresses right after a real clear, then requires the pulse at the exact edge set by that clear alone. A decoder that matched loosely would restart the count and push the pulse later. It measures the clear-to-pulse distance and the pulse-to-pulse distance edge by edge. An extra or missing synchronizer stage, or an off-by-one rollover, shifts those edges. It holds sleep for a known span in run-only mode and requires the pulse delayed by exactly that span. In always-on mode it requires no delay at all, so a mode decoder with the cases swapped fails both checks.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 8;
    localparam logic [BUS_AW-1:0] CLR_ADDR = 8'hCC;
    localparam logic [BUS_DW-1:0] CLR_KEY  = 8'h5A;

    typedef enum logic [1:0] {
        WD_OFF      = 2'b00,
        WD_RUN_ONLY = 2'b01,
        WD_ALWAYS   = 2'b10,
        WD_ALWAYS_B = 2'b11
    } wd_mode_e;

    typedef struct packed {
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_wr_t;

    // True when a bus write targets the clear register with the key.
    function automatic logic is_key_write(bus_wr_t w, logic [BUS_AW-1:0] a,
                                          logic [BUS_DW-1:0] k);
        return w.we && (w.addr == a) && (w.data == k);
    endfunction

    // Whether the counter may advance in a given mode and power state.
    function automatic logic may_count(wd_mode_e m, logic asleep);
        case (m)
            WD_OFF:      return 1'b0;
            WD_RUN_ONLY: return !asleep;
            default:     return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/kwdt_key_tgl.sv
`timescale 1ns/1ps
module kwdt_key_tgl
    import kwdt_pkg::*;
#(
    parameter logic [BUS_AW-1:0] ADDR = CLR_ADDR,
    parameter logic [BUS_DW-1:0] KEY  = CLR_KEY
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    output logic    tgl_o
);
    // Each accepted key write flips the level once.
    always_ff @(posedge clk) begin
        if (rst)
            tgl_o <= 1'b0;
        else if (is_key_write(wr, ADDR, KEY))
            tgl_o <= ~tgl_o;
    end
endmodule

// File: rtl/kwdt_sync.sv
`timescale 1ns/1ps
module kwdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else     st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/kwdt_core.sv
`timescale 1ns/1ps
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int LOG2 = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  wd_mode_e        mode,
    input  logic            sleep_s,
    input  logic            tgl_s,
    output logic            pulse_o,
    output logic            flag_o,
    output logic [LOG2-1:0] cnt_o,
    output logic            clr_o
);
    localparam int CW = LOG2;

    logic [CW-1:0] cnt_q;
    logic          tgl_last;
    logic [CW:0]   sum;
    logic          carry;
    logic          run;

    always_comb begin
        sum   = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
        carry = sum[CW];
        run   = may_count(mode, sleep_s);
        clr_o = tgl_s ^ tgl_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            tgl_last <= 1'b0;
            pulse_o  <= 1'b0;
            flag_o   <= 1'b0;
        end else begin
            tgl_last <= tgl_s;
            pulse_o  <= 1'b0;
            if (clr_o) begin
                cnt_q <= '0;
            end else if (run) begin
                cnt_q <= sum[CW-1:0];
                if (carry) begin
                    pulse_o <= 1'b1;
                    flag_o  <= 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int PERIOD_LOG2 = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst,
    input  logic              lsc_clk,
    input  logic              lsc_rst,
    input  logic [1:0]        mode_i,
    input  logic              sleep_i,
    input  logic              bus_we_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    output logic              wdt_rst_o,
    output logic              ovf_flag_o
);
    bus_wr_t                wr;
    logic                   tgl_cpu;
    logic [1:0]             sync_q;
    logic [PERIOD_LOG2-1:0] cnt_q;
    logic                   clr_w;
    wd_mode_e               mode;

    assign wr   = '{we: bus_we_i, addr: bus_addr_i, data: bus_wdata_i};
    assign mode = wd_mode_e'(mode_i);

    kwdt_key_tgl u_key (
        .clk   (cpu_clk),
        .rst   (cpu_rst),
        .wr    (wr),
        .tgl_o (tgl_cpu)
    );

    kwdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (lsc_clk),
        .rst (lsc_rst),
        .d   ({tgl_cpu, sleep_i}),
        .q   (sync_q)
    );

    kwdt_core #(.LOG2(PERIOD_LOG2)) u_core (
        .clk     (lsc_clk),
        .rst     (lsc_rst),
        .mode    (mode),
        .sleep_s (sync_q[0]),
        .tgl_s   (sync_q[1]),
        .pulse_o (wdt_rst_o),
        .flag_o  (ovf_flag_o),
        .cnt_o   (cnt_q),
        .clr_o   (clr_w)
    );
endmodule

// File: rtl/kwdt_chk.sv
`timescale 1ns/1ps
module kwdt_chk #(
    parameter int CW = 14
) (
    input logic          lsc_clk,
    input logic          lsc_rst,
    input logic [1:0]    mode_i,
    input logic          sleep_s,
    input logic          clr,
    input logic [CW-1:0] cnt,
    input logic          wdt_rst_o,
    input logic          ovf_flag_o
);
    a_r3_one_wide: assert property (@(posedge lsc_clk) disable iff (lsc_rst)
        wdt_rst_o |=> !wdt_rst_o);

    a_r3_restart_zero: assert property (@(posedge lsc_clk) disable iff (lsc_rst)
        wdt_rst_o |-> (cnt == '0));

    a_r4_clear_zeroes: assert property (@(posedge lsc_clk) disable iff (lsc_rst)
        clr |=> (cnt == '0) && !wdt_rst_o);

    a_r7_off_idle: assert property (@(posedge lsc_clk) disable iff (lsc_rst)
        (mode_i == 2'b00) |=> (cnt == '0) && !wdt_rst_o && !ovf_flag_o);

    a_r8_sleep_hold: assert property (@(posedge lsc_clk) disable iff (lsc_rst)
        (mode_i == 2'b01 && sleep_s && !clr) |=> $stable(cnt) && !wdt_rst_o);

    a_r10_sticky: assert property (@(posedge lsc_clk) disable iff (lsc_rst)
        ovf_flag_o |=> ovf_flag_o);

    a_r10_flag_with_pulse: assert property (@(posedge lsc_clk) disable iff (lsc_rst)
        wdt_rst_o |-> ovf_flag_o);
endmodule

bind keyed_wdt kwdt_chk #(.CW(PERIOD_LOG2)) u_chk (
    .lsc_clk    (lsc_clk),
    .lsc_rst    (lsc_rst),
    .mode_i     (mode_i),
    .sleep_s    (sync_q[0]),
    .clr        (clr_w),
    .cnt        (cnt_q),
    .wdt_rst_o  (wdt_rst_o),
    .ovf_flag_o (ovf_flag_o)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;
    localparam int LOG2   = 4;
    localparam int STG    = 2;
    localparam int PERIOD = 1 << LOG2;
    localparam int LAT    = PERIOD + STG + 1;   // clear write to pulse edge

    logic       cpu_clk = 1'b0, lsc_clk = 1'b0;
    logic       cpu_rst = 1'b1, lsc_rst = 1'b1;
    logic [1:0] mode_i  = 2'b01;
    logic       sleep_i = 1'b0;
    logic       bus_we_i = 1'b0;
    logic [7:0] bus_addr_i = '0, bus_wdata_i = '0;
    logic       wdt_rst_o, ovf_flag_o;

    int n_chk = 0, n_bad = 0;
    int lsc_k = 0, pulse_n = 0, last_pulse_k = -1, wide_err = 0;
    logic prev_p = 1'b0;

    always #2.5 cpu_clk = ~cpu_clk;
    always #50  lsc_clk = ~lsc_clk;

    keyed_wdt #(.PERIOD_LOG2(LOG2), .SYNC_STAGES(STG)) u0 (
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .lsc_clk(lsc_clk), .lsc_rst(lsc_rst),
        .mode_i(mode_i), .sleep_i(sleep_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .wdt_rst_o(wdt_rst_o), .ovf_flag_o(ovf_flag_o));

    always @(posedge lsc_clk) lsc_k++;
    always @(negedge lsc_clk) begin
        if (wdt_rst_o) begin
            pulse_n++;
            last_pulse_k = lsc_k;
            if (prev_p) wide_err++;
        end
        prev_p = wdt_rst_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge lsc_clk);
        cpu_rst = 1'b1; lsc_rst = 1'b1; mode_i = m; sleep_i = 1'b0;
        repeat (3) @(negedge lsc_clk);
        cpu_rst = 1'b0; lsc_rst = 1'b0;
    endtask

    task automatic bus_wr(input logic we, input logic [7:0] a, input logic [7:0] d);
        @(negedge cpu_clk);
        bus_we_i = we; bus_addr_i = a; bus_wdata_i = d;
        @(negedge cpu_clk);
        bus_we_i = 1'b0;
    endtask

    task automatic wait_k(input int target);
        while (lsc_k < target) @(negedge lsc_clk);
    endtask

    // Align to a low-speed negedge, return index before the next edge, issue key.
    task automatic key_at(output int k0);
        @(negedge lsc_clk);
        k0 = lsc_k;
        bus_wr(1'b1, 8'hCC, 8'h5A);
    endtask

    initial begin
        #500000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k0, p0;
        // R1: reset state
        @(negedge lsc_clk);
        chk(wdt_rst_o == 1'b0, "R1 pulse in reset", wdt_rst_o, 0);
        chk(ovf_flag_o == 1'b0, "R1 flag in reset", ovf_flag_o, 0);
        do_reset(2'b01);
        @(negedge lsc_clk);
        chk(wdt_rst_o == 1'b0 && ovf_flag_o == 1'b0, "R1 after reset",
            {wdt_rst_o, ovf_flag_o}, 0);

        // R4, R2, R3: key clear timing, free-running interval, width
        p0 = pulse_n;
        key_at(k0);
        wait_k(k0 + LAT + 1);
        chk(pulse_n == p0 + 1, "R4 one pulse after clear", pulse_n - p0, 1);
        chk(last_pulse_k == k0 + LAT, "R4 clear-to-pulse edge", last_pulse_k - k0, LAT);
        wait_k(k0 + LAT + PERIOD + 1);
        chk(pulse_n == p0 + 2, "R2 second pulse", pulse_n - p0, 2);
        chk(last_pulse_k == k0 + LAT + PERIOD, "R2 pulse interval",
            last_pulse_k - k0 - LAT, PERIOD);
        chk(wide_err == 0, "R3 pulse one period wide", wide_err, 0);
        // R10: flag sticky through a clear, cleared by reset
        chk(ovf_flag_o == 1'b1, "R10 flag set", ovf_flag_o, 1);
        bus_wr(1'b1, 8'hCC, 8'h5A);
        repeat (5) @(negedge lsc_clk);
        chk(ovf_flag_o == 1'b1, "R10 flag survives clear", ovf_flag_o, 1);

        // R5: every wrong data value at the clear address is ignored
        do_reset(2'b01);
        chk(ovf_flag_o == 1'b0, "R10 flag cleared by reset", ovf_flag_o, 0);
        p0 = pulse_n;
        key_at(k0);
        for (int v = 0; v < 256; v++)
            if (v != 8'h5A) bus_wr(1'b1, 8'hCC, v[7:0]);
        wait_k(k0 + LAT + 1);
        chk(pulse_n == p0 + 1, "R5 pulse count", pulse_n - p0, 1);
        chk(last_pulse_k == k0 + LAT, "R5 wrong data ignored", last_pulse_k - k0, LAT);

        // R6: key to every other address, and strobe low, are ignored
        do_reset(2'b01);
        p0 = pulse_n;
        key_at(k0);
        for (int a = 0; a < 256; a++)
            if (a != 8'hCC) bus_wr(1'b1, a[7:0], 8'h5A);
        bus_wr(1'b0, 8'hCC, 8'h5A);
        wait_k(k0 + LAT + 1);
        chk(pulse_n == p0 + 1, "R6 pulse count", pulse_n - p0, 1);
        chk(last_pulse_k == k0 + LAT, "R6 wrong address ignored", last_pulse_k - k0, LAT);

        // R7: off mode never fires
        do_reset(2'b00);
        p0 = pulse_n;
        key_at(k0);
        wait_k(k0 + 4 * PERIOD);
        chk(pulse_n == p0, "R7 no pulse when off", pulse_n - p0, 0);
        chk(ovf_flag_o == 1'b0, "R7 no flag when off", ovf_flag_o, 0);

        // R8: run-only, sleep for 7 periods delays pulse by 7
        do_reset(2'b01);
        p0 = pulse_n;
        key_at(k0);
        wait_k(k0 + 5);
        sleep_i = 1'b1;
        wait_k(k0 + 12);
        sleep_i = 1'b0;
        wait_k(k0 + LAT + 7 + 1);
        chk(pulse_n == p0 + 1, "R8 pulse count", pulse_n - p0, 1);
        chk(last_pulse_k == k0 + LAT + 7, "R8 sleep pauses count", last_pulse_k - k0, LAT + 7);

        // R9: always-on (both codes), sleep has no effect
        for (int m = 2; m < 4; m++) begin
            do_reset(m[1:0]);
            p0 = pulse_n;
            key_at(k0);
            wait_k(k0 + 5);
            sleep_i = 1'b1;
            wait_k(k0 + 12);
            sleep_i = 1'b0;
            wait_k(k0 + LAT + 1);
            chk(pulse_n == p0 + 1, "R9 pulse count", pulse_n - p0, 1);
            chk(last_pulse_k == k0 + LAT, "R9 sleep ignored", last_pulse_k - k0, LAT);
        end
        chk(wide_err == 0, "R3 all pulses one wide", wide_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule